// File: doc/BRIEF.md
# Dithered Oscillator Downmixer

This block translates a real intermediate-frequency sample stream to complex baseband. A 28-bit phase register moves forward by a programmable step each time a valid input sample arrives. Before the phase is cut down to the 12 bits that address a sine/cosine table, the 16 discarded low bits receive pseudo-random dither from a free-running shift-register generator. The dither spreads the truncation error as noise rather than leaving it as discrete spurs.

The table yields a cosine and sine pair in signed Q1.15. Two multipliers scale the 16-bit real input sample by each of them and produce the in-phase and quadrature outputs. Each output is an 18-bit value with 16 fractional bits, and it comes with a valid flag. A negative step turns the phasor clockwise, which shifts a carrier down toward zero frequency. For example, at a 122.88 MHz sample rate a 32 MHz carrier needs step 0xBD55555, which is -69905067 modulo 2^28. Filtering and decimation are left to the stages that follow.

Top module: `if_nco_mixer`

## Requirements
- R1: While `rst_n` is low at a clock edge, and directly after release, `out_valid`, `out_i` and `out_q` read 0. The phase register clears to 0 and the dither generator loads seed 0xACE1.
- R2: Sample n after reset is mixed with phase P(n). P(0) is 0, and P(n) is the sum of the `phase_step` values of the n earlier valid samples, taken modulo 2^28.
- R3: A cycle with `in_valid` low moves neither the phase register nor the dither generator, and the values on `phase_step` and `in_sample` in that cycle have no effect.
- R4: The table index is bits 27:16 of (P(n) + D(n)) modulo 2^28, where D(n) is the 16-bit generator state zero-extended. D(0) is 0xACE1, and the next state is {D[14:0], D[15]^D[13]^D[12]^D[10]}, taken once per valid sample. When the low 16 bits of P(n) are zero, the index is exactly P(n)[27:16].
- R5: Index k selects cos and sin of 2πk/4096, each scaled by 32767 and rounded to the nearest integer (within one LSB). The index wraps across all four quadrants.
- R6: `out_i` = floor(x·cos/2^14) and `out_q` = floor(x·sin/2^14), wrapped to 18 bits, where x is `in_sample` read as two's complement. This includes x = -32768 at the table's extreme values (±65534).
- R7: `out_valid` is `in_valid` delayed by exactly three clock cycles. While `out_valid` is low, `out_i` and `out_q` hold their last values.
- R8: A negative step wraps modulo 2^28. The 32 MHz downconversion step 0xBD55555 follows R2 to R6 over a long run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_step | input | 28 | Phase increment per valid sample, two's complement |
| in_valid | input | 1 | Marks `in_sample` as a real sample |
| in_sample | input | 16 | Real input, signed Q1.15 |
| out_valid | output | 1 | Marks `out_i`/`out_q` as freshly produced |
| out_i | output | 18 | In-phase output, signed Q2.16 |
| out_q | output | 18 | Quadrature output, signed Q2.16 |

## Verification
The hardest behaviour to reach from the ports is dither actually changing the table index. This needs the phase's low 16 bits to sit where the generator value decides whether a carry enters the index, and the only evidence is a sine output that shifts by about one table step. The stimulus uses a step of 0x8000, so that every other sample has low bits at half scale. The bench then models the dither generator from the stated polynomial and seed, and predicts which samples carry. A full 4096-step sweep reaches every quarter-wave mirror point, including the index-1024 entry that only the mirrored address can select.

// File: rtl/nco_mix_pkg.sv
// Shared constants and the elaboration-time sine generator for the
// dithered downmixer. Assumes 64-bit integer arithmetic at elaboration.
package nco_mix_pkg;

    // pi scaled by 2^30
    localparam longint PI_Q30 = 64'sd3373259426;

    // Quarter-wave sine sample k of 2^(tbl_w-2), scaled to amp, rounded.
    // Five-term odd series on [0, pi/2]; residual error far below 1 LSB.
    function automatic longint quarter_sine(input int k, input int tbl_w, input longint amp);
        longint x;
        longint x2;
        longint term;
        longint sum;
        x    = (longint'(k) * PI_Q30) >>> (tbl_w - 1);
        x2   = (x * x) >>> 30;
        term = x;
        sum  = x;
        for (int n = 1; n <= 5; n++) begin
            term = -((term * x2) >>> 30) / longint'((2 * n) * (2 * n + 1));
            sum  = sum + term;
        end
        return (sum * amp + (longint'(1) <<< 29)) >>> 30;
    endfunction

endpackage

// File: rtl/nco_phase_gen.sv
// Phase register, dither generator and first pipeline stage.
// Assumes ACC_W > TBL_W and that TAPS describes a maximal-length
// Fibonacci generator of width ACC_W-TBL_W with a non-zero SEED.
module nco_phase_gen #(
    parameter int ACC_W  = 28,
    parameter int TBL_W  = 12,
    parameter int DATA_W = 16,
    parameter logic [ACC_W-TBL_W-1:0] SEED = 16'hACE1,
    parameter logic [ACC_W-TBL_W-1:0] TAPS = 16'hB400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ACC_W-1:0]  step,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    output logic [TBL_W-1:0]  idx_q,
    output logic [DATA_W-1:0] smp_q,
    output logic              vld_q
);
    localparam int DW = ACC_W - TBL_W;

    logic [ACC_W-1:0] acc_q;
    logic [DW-1:0]    lfsr_q;
    logic             carry;
    logic [TBL_W-1:0] idx_next;

    // Dither carry: low phase bits plus dither overflow past 2^DW.
    always_comb begin
        carry    = (acc_q[DW-1:0] > ~lfsr_q);
        idx_next = acc_q[ACC_W-1 -: TBL_W] + TBL_W'(carry);
    end

    // Phase register and dither generator advance on valid samples only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            lfsr_q <= SEED;
        end else if (in_valid) begin
            acc_q  <= acc_q + step;
            lfsr_q <= {lfsr_q[DW-2:0], ^(lfsr_q & TAPS)};
        end
    end

    // Stage 1: capture table index and sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            idx_q <= '0;
            smp_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                idx_q <= idx_next;
                smp_q <= in_sample;
            end
        end
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0); // R4
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(acc_q) && $stable(lfsr_q))); // R3
    AST_IDX_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((idx_q == $past(acc_q[ACC_W-1 -: TBL_W])) ||
                      (idx_q == $past(acc_q[ACC_W-1 -: TBL_W]) + 1'b1))); // R4
endmodule

// File: rtl/nco_sincos_lut.sv
// Quarter-wave sine/cosine lookup, second pipeline stage.
// The table holds 2^(TBL_W-2)+1 magnitudes so the quarter-point
// entry exists; other quadrants are mirrored and negated.
module nco_sincos_lut #(
    parameter int TBL_W  = 12,
    parameter int AMP_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TBL_W-1:0]         idx,
    input  logic [DATA_W-1:0]        smp_in,
    input  logic                     vld_in,
    output logic signed [AMP_W-1:0]  cos_q,
    output logic signed [AMP_W-1:0]  sin_q,
    output logic [DATA_W-1:0]        smp_q,
    output logic                     vld_q
);
    localparam int QB  = TBL_W - 2;
    localparam int QN  = 1 << QB;
    localparam int AMP = (1 << (AMP_W - 1)) - 1;

    logic [AMP_W-1:0] qtab [QN+1];

    for (genvar k = 0; k <= QN; k++) begin : g_tab
        assign qtab[k] = AMP_W'(nco_mix_pkg::quarter_sine(k, TBL_W, longint'(AMP)));
    end

    // Channel 0 is sine, channel 1 is sine advanced by a quarter turn.
    for (genvar ch = 0; ch < 2; ch++) begin : g_ch
        localparam logic [TBL_W-1:0] OFS = (ch == 0) ? '0 : TBL_W'(QN);
        logic [TBL_W-1:0]         ph;
        logic [QB:0]              addr;
        logic [AMP_W-1:0]         mag;
        logic signed [AMP_W-1:0]  val;
        // Fold the phase into the first quadrant and restore the sign.
        always_comb begin
            ph   = idx + OFS;
            addr = ph[TBL_W-2] ? ((QB+1)'(QN) - {1'b0, ph[QB-1:0]}) : {1'b0, ph[QB-1:0]};
            mag  = qtab[addr];
            val  = ph[TBL_W-1] ? -$signed(mag) : $signed(mag);
        end
    end

    // Stage 2: register the phasor alongside its sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            sin_q <= '0;
            cos_q <= '0;
            smp_q <= '0;
        end else begin
            vld_q <= vld_in;
            if (vld_in) begin
                sin_q <= g_ch[0].val;
                cos_q <= g_ch[1].val;
                smp_q <= smp_in;
            end
        end
    end

    AST_ZERO_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_in && idx == '0) |=> (int'(cos_q) == AMP && sin_q == '0)); // R5
    AST_UNIT_CIRCLE: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> (((sin_q < 0) ? -int'(sin_q) : int'(sin_q)) +
                   ((cos_q < 0) ? -int'(cos_q) : int'(cos_q)) >= AMP - 2)); // R5
endmodule

// File: rtl/nco_cmul.sv
// Real-by-complex mixer, third pipeline stage. Products are floored
// by SHIFT bits and wrapped to OUT_W; outputs hold on idle cycles.
module nco_cmul #(
    parameter int DATA_W = 16,
    parameter int AMP_W  = 16,
    parameter int OUT_W  = 18,
    parameter int SHIFT  = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [DATA_W-1:0] smp,
    input  logic signed [AMP_W-1:0]  cos_in,
    input  logic signed [AMP_W-1:0]  sin_in,
    input  logic                     vld_in,
    output logic signed [OUT_W-1:0]  out_i,
    output logic signed [OUT_W-1:0]  out_q,
    output logic                     out_v
);
    localparam int PW = DATA_W + AMP_W;

    logic signed [PW-1:0] prod_i;
    logic signed [PW-1:0] prod_q;

    // Full-precision products.
    always_comb begin
        prod_i = smp * cos_in;
        prod_q = smp * sin_in;
    end

    // Stage 3: floor, wrap and register the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_v <= 1'b0;
            out_i <= '0;
            out_q <= '0;
        end else begin
            out_v <= vld_in;
            if (vld_in) begin
                out_i <= OUT_W'(prod_i >>> SHIFT);
                out_q <= OUT_W'(prod_q >>> SHIFT);
            end
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_in |=> ($stable(out_i) && $stable(out_q))); // R7
    AST_ZERO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_in && smp == '0) |=> (out_i == '0 && out_q == '0)); // R6
endmodule

// File: rtl/if_nco_mixer.sv
// Dithered oscillator downmixer: phase/dither stage, table stage and
// mixer stage, three cycles from input to output.
module if_nco_mixer #(
    parameter int ACC_W    = 28,
    parameter int TBL_W    = 12,
    parameter int DATA_W   = 16,
    parameter int AMP_W    = 16,
    parameter int OUT_W    = 18,
    parameter int OUT_FRAC = 16,
    parameter logic [ACC_W-TBL_W-1:0] DITHER_SEED = 16'hACE1,
    parameter logic [ACC_W-TBL_W-1:0] DITHER_TAPS = 16'hB400
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ACC_W-1:0]        phase_step,
    input  logic                    in_valid,
    input  logic [DATA_W-1:0]       in_sample,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_i,
    output logic signed [OUT_W-1:0] out_q
);
    localparam int SHIFT = (DATA_W - 1) + (AMP_W - 1) - OUT_FRAC;

    logic [TBL_W-1:0]         s1_idx;
    logic [DATA_W-1:0]        s1_smp;
    logic                     s1_vld;
    logic signed [AMP_W-1:0]  s2_cos;
    logic signed [AMP_W-1:0]  s2_sin;
    logic [DATA_W-1:0]        s2_smp;
    logic                     s2_vld;

    nco_phase_gen #(
        .ACC_W(ACC_W), .TBL_W(TBL_W), .DATA_W(DATA_W),
        .SEED(DITHER_SEED), .TAPS(DITHER_TAPS)
    ) u_phase (
        .clk(clk), .rst_n(rst_n), .step(phase_step), .in_valid(in_valid),
        .in_sample(in_sample), .idx_q(s1_idx), .smp_q(s1_smp), .vld_q(s1_vld)
    );

    nco_sincos_lut #(
        .TBL_W(TBL_W), .AMP_W(AMP_W), .DATA_W(DATA_W)
    ) u_lut (
        .clk(clk), .rst_n(rst_n), .idx(s1_idx), .smp_in(s1_smp), .vld_in(s1_vld),
        .cos_q(s2_cos), .sin_q(s2_sin), .smp_q(s2_smp), .vld_q(s2_vld)
    );

    nco_cmul #(
        .DATA_W(DATA_W), .AMP_W(AMP_W), .OUT_W(OUT_W), .SHIFT(SHIFT)
    ) u_mix (
        .clk(clk), .rst_n(rst_n), .smp($signed(s2_smp)), .cos_in(s2_cos),
        .sin_in(s2_sin), .vld_in(s2_vld), .out_i(out_i), .out_q(out_q), .out_v(out_valid)
    );

    // Cycles since reset release, saturating, to bound the latency check.
    logic [1:0] since_rst_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst_q <= '0;
        else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R7
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_i == '0 && out_q == '0)); // R1
endmodule

// File: tb/if_nco_mixer_tb_top.sv
module if_nco_mixer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] phase_step = '0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic        out_valid;
    logic signed [17:0] out_i;
    logic signed [17:0] out_q;

    always #10 clk = ~clk;

    if_nco_mixer dut_i (
        .clk(clk), .rst_n(rst_n), .phase_step(phase_step), .in_valid(in_valid),
        .in_sample(in_sample), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model state
    logic [27:0] m_acc;
    logic [15:0] m_lfsr;
    int          last_i, last_q;
    logic        p_v [3];
    int          p_i [3];
    int          p_q [3];
    string       p_req [3];

    typedef struct packed {
        logic        v;
        logic [27:0] step;
        logic [15:0] x;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 28'h0100000, 16'h4000},
        '{1'b1, 28'h0400000, 16'h7FFF},
        '{1'b1, 28'h4000000, 16'h8000},
        '{1'b0, 28'h4000000, 16'h1111},
        '{1'b1, 28'h4000000, 16'hC000},
        '{1'b1, 28'h8000000, 16'h8000},
        '{1'b1, 28'hFFF0000, 16'h1234},
        '{1'b0, 28'h0000000, 16'h0000},
        '{1'b1, 28'h0008000, 16'h7FFF},
        '{1'b1, 28'h0008000, 16'h7FFF},
        '{1'b1, 28'h0008000, 16'h8001},
        '{1'b1, 28'h0012345, 16'h2000},
        '{1'b1, 28'h0012345, 16'hE000},
        '{1'b1, 28'h0000000, 16'h0000}
    };

    function automatic int iabs(input int a);
        return (a < 0) ? -a : a;
    endfunction

    // Expected mixer output for sample x at table index k (R5, R6).
    function automatic int exp_mix(input logic [15:0] x, input int k, input bit use_sin);
        real th;
        int  c;
        int  p;
        th = 2.0 * 3.14159265358979 * real'(k) / 4096.0;
        c  = $rtoi($floor(32767.0 * (use_sin ? $sin(th) : $cos(th)) + 0.5));
        p  = int'($signed(x)) * c;
        return p >>> 14;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        phase_step = '0;
        in_sample = '0;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_i !== '0 || out_q !== '0) begin
            fails++;
            $display("FAIL R1: valid=%0b i=%0d q=%0d expected valid=0 i=0 q=0",
                     out_valid, out_i, out_q);
        end
        rst_n  = 1'b1;
        m_acc  = '0;
        m_lfsr = 16'hACE1;
        last_i = 0;
        last_q = 0;
        for (int k = 0; k < 3; k++) begin
            p_v[k] = 1'b0; p_i[k] = 0; p_q[k] = 0; p_req[k] = "R1";
        end
    endtask

    // One cycle: compare the output due now, then drive and predict.
    task automatic cyc(input logic v, input logic [27:0] st, input logic [15:0] x,
                       input string req);
        int ai, aq, k;
        logic [27:0] sum;
        @(negedge clk);
        ai = int'(out_i);
        aq = int'(out_q);
        checks++;
        if (out_valid !== p_v[2] || iabs(ai - p_i[2]) > 3 || iabs(aq - p_q[2]) > 3) begin
            fails++;
            $display("FAIL %s: valid=%0b i=%0d q=%0d expected valid=%0b i=%0d q=%0d",
                     p_req[2], out_valid, ai, aq, p_v[2], p_i[2], p_q[2]);
        end
        in_valid   = v;
        phase_step = st;
        in_sample  = x;
        if (v) begin
            sum    = m_acc + {12'h000, m_lfsr};
            k      = int'(sum[27:16]);
            last_i = exp_mix(x, k, 1'b0);
            last_q = exp_mix(x, k, 1'b1);
            m_acc  = m_acc + st;
            m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        end
        for (int s = 2; s > 0; s--) begin
            p_v[s] = p_v[s-1]; p_i[s] = p_i[s-1]; p_q[s] = p_q[s-1]; p_req[s] = p_req[s-1];
        end
        p_v[0] = v; p_i[0] = last_i; p_q[0] = last_q; p_req[0] = req;
    endtask

    task automatic drain(input string req);
        repeat (4) cyc(1'b0, 28'h0, 16'h0, req);
    endtask

    initial begin
        // R1: reset state, then R2 over the vector table
        do_reset();
        for (int n = 0; n < NV; n++) cyc(VECS[n].v, VECS[n].step, VECS[n].x, "R2");
        drain("R2");

        // R7: single pulse, then outputs hold while idle
        cyc(1'b1, 28'h0200000, 16'h3000, "R7");
        repeat (5) cyc(1'b0, 28'h0, 16'h7777, "R7");

        // R3: idle cycles with garbage step and sample change nothing
        cyc(1'b1, 28'h0300000, 16'h6000, "R3");
        repeat (4) cyc(1'b0, 28'h1234567, 16'h1111, "R3");
        cyc(1'b1, 28'h0300000, 16'h6000, "R3");
        cyc(1'b1, 28'h0300000, 16'h9000, "R3");
        drain("R3");

        // R4: dither decides carries at half-scale low bits
        do_reset();
        repeat (24) cyc(1'b1, 28'h0008000, 16'h7FFF, "R4");
        repeat (8) cyc(1'b1, 28'h0010000, 16'h7FFF, "R4");
        drain("R4");

        // R6: extreme inputs at table extremes
        do_reset();
        cyc(1'b1, 28'h8000000, 16'h8000, "R6");
        cyc(1'b1, 28'h4000000, 16'h8000, "R6");
        cyc(1'b1, 28'h4000000, 16'h8000, "R6");
        cyc(1'b1, 28'h4000000, 16'h7FFF, "R6");
        cyc(1'b1, 28'h0000000, 16'h8000, "R6");
        drain("R6");

        // R5: full table sweep through all quadrants
        do_reset();
        repeat (4096) cyc(1'b1, 28'h0010000, 16'h7FFF, "R5");
        drain("R5");

        // R8: negative carrier step wraps
        do_reset();
        repeat (64) cyc(1'b1, 28'hBD55555, 16'h5A5A, "R8");
        drain("R8");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule